// File: doc/BRIEF.md
# Trigger-Driven DAC Update Controller

This block is the digital side of one D/A converter channel. Software-style write strobes load an output code into a value register and set a channel enable bit and a mode bit. When a conversion starts, the block copies a code into a converter-input register that drives the analog stage. It then counts a fixed settling interval and raises a valid flag once the analog output can be trusted.

In normal mode, the channel converts as soon as it is enabled or as soon as a new code is written. In real-time mode, writes only stage the next code. Each one-cycle external trigger pulse starts a conversion with whatever code the value register holds at that moment. A trigger that arrives while the output is still settling abandons that conversion and starts a fresh one with the full wait. Clearing the enable bit stops everything and returns the converter input to zero.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake. A write is taken in the cycle its strobe is high, and the block never pushes back.

Top module: `trig_dac_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, `busy` and `valid` are 0, the channel is disabled and the mode is normal (mode bit 0). The staged value is 0.
- R2: In normal mode (mode bit 0) with the channel enabled, a value write starts a conversion at that clock edge. `dac_code` takes the written value. `busy` is then high for exactly SETTLE cycles, after which `valid` goes high.
- R3: A control write that sets the enable bit from 0 to 1 with mode bit 0 starts a conversion. It uses the staged value, or the value written in the same cycle if there is one. The full settling wait follows.
- R4: In real-time mode (mode bit 1), a value write only updates the staged value. It does not change `dac_code`, `busy` or `valid`.
- R5: In real-time mode with the channel enabled, a one-cycle `trig` pulse starts a conversion. `dac_code` takes the staged value and the settling wait follows.
- R6: A trigger during settling abandons the current conversion. It reloads the settling count, and `valid` rises only SETTLE cycles after the last trigger.
- R7: If a trigger and a value write occur in the same cycle in real-time mode, the conversion still starts and uses the value staged before the write. The written value is kept for the next trigger.
- R8: A control write with the enable bit at 0 forces `busy`, `valid` and `dac_code` to 0 in the next cycle. While the channel is disabled, neither writes nor triggers start a conversion.
- R9: Setting the enable bit to 1, then 0, then 1 imposes the full SETTLE-cycle wait, counted from the last setting to 1.
- R10: In normal mode, `trig` has no effect on `dac_code`, `busy` or `valid`.
- R11: `busy` and `valid` are never both high. `valid` stays high until the next conversion starts or the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| val_we | input | 1 | Value-register write strobe |
| val_wdata | input | DATA_W | Code to stage |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_en | input | 1 | Enable bit to write (1 = run) |
| ctl_mode | input | 1 | Mode bit to write (0 normal, 1 real-time) |
| trig | input | 1 | One-cycle conversion trigger |
| dac_code | output | DATA_W | Converter-input register |
| busy | output | 1 | Settling in progress |
| valid | output | 1 | Output settled |

## Verification
The in-line assertions check the following on every cycle:
- `busy` and `valid` are exclusive.
- Every start loads the selected code and reloads the count.
- An expired count raises `valid`.
- A disable clears all outputs.
- `dac_code` never changes except at a start or a clear.
- A real-time write without a trigger starts nothing.

Only the bench scenarios can show the rest: the exact length of the settling window, the restart after a trigger at each offset within settling, the code chosen when a trigger and a write collide, and the fresh wait after an enable toggle. The same applies to triggers being ignored in normal mode and to disabled-channel immunity, seen at the ports.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_REALTIME = 1'b1
  } dac_mode_e;

  typedef struct packed {
    logic      en;
    dac_mode_e mode;
  } dac_ctl_t;

  function automatic int cnt_width(input int settle);
    return (settle > 1) ? $clog2(settle) : 1;
  endfunction
endpackage

// File: rtl/dacu_regs.sv
module dacu_regs
  import dacu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_we,
  input  logic [DATA_W-1:0] val_wdata,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic              ctl_mode,
  input  logic              trig,
  output logic              start,
  output logic [DATA_W-1:0] start_code,
  output logic              clear
);
  logic [DATA_W-1:0] value_q;
  dac_ctl_t          ctl_q;
  dac_mode_e         next_mode;
  logic              en_rise;
  logic              norm_start;
  logic              rt_start;

  assign clear     = ctl_we && !ctl_en;
  assign next_mode = ctl_we ? dac_mode_e'(ctl_mode) : ctl_q.mode;
  assign en_rise   = ctl_we && ctl_en && !ctl_q.en;

  always_comb begin
    norm_start = 1'b0;
    if (en_rise && next_mode == MODE_NORMAL)
      norm_start = 1'b1;
    else if (ctl_q.en && ctl_q.mode == MODE_NORMAL && val_we && !clear)
      norm_start = 1'b1;
  end

  assign rt_start = ctl_q.en && (ctl_q.mode == MODE_REALTIME) && trig && !clear;
  assign start    = norm_start || rt_start;

  always_comb begin
    if (rt_start)    start_code = value_q;
    else if (val_we) start_code = val_wdata;
    else             start_code = value_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      ctl_q   <= '{en: 1'b0, mode: MODE_NORMAL};
    end else begin
      if (val_we) value_q <= val_wdata;
      if (ctl_we) begin
        ctl_q.en   <= ctl_en;
        ctl_q.mode <= dac_mode_e'(ctl_mode);
      end
    end
  end

  // R4: staging in real-time mode must not start a conversion
  a_r4_rt_write_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && ctl_q.mode == MODE_REALTIME && val_we && !trig && !ctl_we) |-> !start);

  // R8: nothing starts while disabled unless being enabled
  a_r8_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !ctl_we) |-> !start);
endmodule

// File: rtl/dacu_settle.sv
module dacu_settle
  import dacu_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic busy,
  output logic valid
);
  localparam int CW = cnt_width(SETTLE);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= LOAD;
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy  = busy_q;
  assign valid = valid_q;

  // R11: flags never overlap
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && valid_q));

  // R6: every start reloads the full count
  a_r6_start_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clear) |=> (busy_q && !valid_q && cnt_q == LOAD));

  // R2: an expired count raises valid
  a_r2_expire_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && !start && !clear) |=> (valid_q && !busy_q));

  // R8: a disable drops both flags
  a_r8_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy_q && !valid_q));

  // R11: valid holds until a start or a clear
  a_r11_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !start && !clear) |=> valid_q);
endmodule

// File: rtl/dacu_code.sv
module dacu_code #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  logic [DATA_W-1:0] start_code,
  output logic [DATA_W-1:0] code
);
  logic [DATA_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) code_q <= '0;
    else if (start)      code_q <= start_code;
  end

  assign code = code_q;

  // R2: a start loads the selected code
  a_r2_code_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clear) |=> code_q == $past(start_code));

  // R8: a disable zeroes the converter input
  a_r8_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> code_q == '0);

  // R5: the converter input moves only at a start or a clear
  a_r5_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clear) |=> $stable(code_q));
endmodule

// File: rtl/trig_dac_ctrl.sv
module trig_dac_ctrl #(
  parameter int DATA_W = 8,
  parameter int SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_we,
  input  logic [DATA_W-1:0] val_wdata,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic              ctl_mode,
  input  logic              trig,
  output logic [DATA_W-1:0] dac_code,
  output logic              busy,
  output logic              valid
);
  logic              start;
  logic              clear;
  logic [DATA_W-1:0] start_code;

  dacu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .val_we(val_we), .val_wdata(val_wdata),
    .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_mode(ctl_mode), .trig(trig),
    .start(start), .start_code(start_code), .clear(clear)
  );

  dacu_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .busy(busy), .valid(valid)
  );

  dacu_code #(.DATA_W(DATA_W)) u_code (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .start_code(start_code), .code(dac_code)
  );
endmodule

// File: tb/sim_trig_dac_ctrl.sv
module sim_trig_dac_ctrl;
  localparam int DW = 8;
  localparam int ST = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic val_we = 1'b0;
  logic [DW-1:0] val_wdata = '0;
  logic ctl_we = 1'b0, ctl_en = 1'b0, ctl_mode = 1'b0, trig = 1'b0;
  logic [DW-1:0] dac_code;
  logic busy, valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_dac_ctrl #(.DATA_W(DW), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .val_we(val_we), .val_wdata(val_wdata),
    .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_mode(ctl_mode), .trig(trig),
    .dac_code(dac_code), .busy(busy), .valid(valid)
  );

  task automatic chk(input string req, input logic [DW-1:0] ec, input logic eb, input logic ev);
    checks++;
    if (dac_code !== ec || busy !== eb || valid !== ev) begin
      errors++;
      $display("FAIL %s: code=%0h busy=%0b valid=%0b expected code=%0h busy=%0b valid=%0b",
               req, dac_code, busy, valid, ec, eb, ev);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr_val(input logic [DW-1:0] v);
    val_we = 1'b1; val_wdata = v;
    @(negedge clk);
    val_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic en, input logic md);
    ctl_we = 1'b1; ctl_en = en; ctl_mode = md;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic pulse(input logic with_wr, input logic [DW-1:0] v);
    trig = 1'b1; val_we = with_wr; val_wdata = v;
    @(negedge clk);
    trig = 1'b0; val_we = 1'b0;
  endtask

  // called at the negedge right after the start edge
  task automatic settle(input string req, input logic [DW-1:0] c);
    for (int j = 0; j < ST; j++) begin
      chk(req, c, 1'b1, 1'b0);
      @(negedge clk);
    end
    chk(req, c, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R1", 8'h00, 1'b0, 1'b0);

    // R8: disabled channel ignores writes
    wr_val(8'h3C);
    chk("R8", 8'h00, 1'b0, 1'b0);

    // R3: enable in normal mode uses the staged value
    wr_ctl(1'b1, 1'b0);
    settle("R3", 8'h3C);

    // R2: sweep of codes in normal mode
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] v;
      v = DW'((i * 37 + 1) & 8'hFF);
      wr_val(v);
      settle("R2", v);
      idle();
      chk("R11", v, 1'b0, 1'b1);
    end

    // R10: trigger ignored in normal mode
    pulse(1'b0, 8'h00);
    chk("R10", DW'((7 * 37 + 1) & 8'hFF), 1'b0, 1'b1);

    // R9: toggle enable 1,0,1 gives a fresh wait
    wr_ctl(1'b0, 1'b0);
    chk("R8", 8'h00, 1'b0, 1'b0);
    wr_ctl(1'b1, 1'b0);
    idle();
    wr_ctl(1'b0, 1'b0);
    wr_ctl(1'b1, 1'b0);
    settle("R9", DW'((7 * 37 + 1) & 8'hFF));

    // R3: enable with a same-cycle write uses the written value
    wr_ctl(1'b0, 1'b0);
    ctl_we = 1'b1; ctl_en = 1'b1; ctl_mode = 1'b0; val_we = 1'b1; val_wdata = 8'hE1;
    @(negedge clk);
    ctl_we = 1'b0; val_we = 1'b0;
    settle("R3", 8'hE1);

    // switch to real-time mode: no start on mode change
    wr_ctl(1'b1, 1'b1);
    chk("R4", 8'hE1, 1'b0, 1'b1);

    // R4: staging does not touch outputs
    wr_val(8'h11);
    chk("R4", 8'hE1, 1'b0, 1'b1);

    // R5: trigger loads staged value
    pulse(1'b0, 8'h00);
    settle("R5", 8'h11);

    // R6: restart at every offset within settling
    for (int k = 0; k <= ST - 3; k++) begin
      logic [DW-1:0] a, b;
      a = DW'(8'h20 + k);
      b = DW'(8'hA0 + k);
      wr_val(a);
      pulse(1'b0, 8'h00);
      chk("R5", a, 1'b1, 1'b0);
      wr_val(b);
      chk("R6", a, 1'b1, 1'b0);
      for (int j = 0; j < k; j++) begin
        chk("R6", a, 1'b1, 1'b0);
        idle();
      end
      pulse(1'b0, 8'h00);
      settle("R6", b);
    end

    // R7: trigger and write together
    wr_val(8'h5A);
    idle();
    pulse(1'b1, 8'hC3);
    settle("R7", 8'h5A);
    pulse(1'b0, 8'h00);
    settle("R7", 8'hC3);

    // R8: disable mid-settling, then triggers ignored
    pulse(1'b0, 8'h00);
    idle();
    wr_ctl(1'b0, 1'b1);
    chk("R8", 8'h00, 1'b0, 1'b0);
    pulse(1'b0, 8'h00);
    chk("R8", 8'h00, 1'b0, 1'b0);
    pulse(1'b1, 8'h77);
    chk("R8", 8'h00, 1'b0, 1'b0);

    // R5: re-enable in real-time waits for trigger
    wr_ctl(1'b1, 1'b1);
    chk("R5", 8'h00, 1'b0, 1'b0);
    pulse(1'b0, 8'h00);
    settle("R9", 8'h77);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expected=done actual=hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule